// File: doc/BRIEF.md
# Programmable Block Address Sequencer

This block generates memory addresses for algorithms that walk a buffer in blocks, such as the stages of an in-place FFT. Each sequence is described by a start address, a step used inside a block, a block size, a number of blocks and a step from one block base to the next. Address k of block b is start + b × block_step + k × step, taken modulo the width of the sequence. A start pulse captures the configuration inputs. After that, one address is emitted on every clock cycle in which the enable input is high, until the last address of the last block is emitted together with a done flag.

The block has two lanes of 12 bits each. In dual mode the lanes run as independent sequences, one for reads and one for writes. Each lane has its own configuration. The upper lane can be delayed by 0 to 15 cycles so that its writes line up with the results of a pipelined datapath. In wide mode the two lanes form one 24-bit sequence. The block counts come from the lower lane's configuration, carries pass from the lower lane into the upper lane, and no delay is applied.

Top module: `abs_addr_seq`

## Requirements
- R1: While reset is held and after it is released, both lanes drive valid = 0, done = 0 and address 0 until the first emitted address.
- R2: A start pulse captures the configuration and restarts both lanes. No address is emitted in the start cycle. In each later cycle with en = 1, the next address is registered and appears with valid = 1 in the cycle after that en cycle. The first address is the start address.
- R3: Inside a block, consecutive addresses differ by the step, and a block contains exactly block-size addresses.
- R4: The first block base is the start address. Each later block base is the previous base plus the block step.
- R5: In dual mode, all address arithmetic of each lane wraps modulo 2^12.
- R6: Done is high for exactly one cycle, together with the valid final address. After it, valid stays low until the next start.
- R7: A cycle with en = 0 emits nothing (valid = 0, address held) and does not advance the sequence.
- R8: A start while a sequence is running abandons that sequence and begins the new configuration.
- R9: With wide_mode = 1 at start, {hi_addr, lo_addr} follows the 24-bit sequence built from {hi,lo} start, step and block step. The block size and block count come from the lo inputs. The hi outputs are aligned with the lo outputs whatever the skew setting.
- R10: With wide_mode = 0 at start, the hi lane runs its own sequence from the hi configuration, independently of the lo lane.
- R11: In dual mode, the hi outputs (valid, done, address) equal the undelayed hi stream delayed by skew cycles (0 to 15, captured at start). Setting 0 gives no delay.
- R12: A start with block size 0 or block count 0 in a lane emits no address on that lane.
- R13: Changes to the configuration inputs without a start do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and restart the sequences |
| en | input | 1 | Emit one address per high cycle |
| wide_mode | input | 1 | 1: one 24-bit sequence, 0: two 12-bit sequences |
| skew | input | 4 | Delay of the hi lane in cycles (dual mode) |
| lo_start | input | 12 | Lower lane start address |
| lo_step | input | 12 | Lower lane in-block step |
| lo_bstep | input | 12 | Lower lane block-to-block step |
| lo_bsize | input | 13 | Lower lane addresses per block |
| lo_nblk | input | 13 | Lower lane number of blocks |
| hi_start | input | 12 | Upper lane start address |
| hi_step | input | 12 | Upper lane in-block step |
| hi_bstep | input | 12 | Upper lane block-to-block step |
| hi_bsize | input | 13 | Upper lane addresses per block (dual mode) |
| hi_nblk | input | 13 | Upper lane number of blocks (dual mode) |
| lo_valid | output | 1 | Lower lane address valid |
| lo_done | output | 1 | Lower lane final address |
| lo_addr | output | 12 | Lower lane address |
| hi_valid | output | 1 | Upper lane address valid |
| hi_done | output | 1 | Upper lane final address |
| hi_addr | output | 12 | Upper lane address |

## Verification
The count from 0 to 7 with a unit step separates a correct in-block counter from one that is off by one, and checks the done timing. Several blocks with a large block step show whether the base advances from the previous base or from the last address. Starts placed near 0xFFF with negative steps expose wrong wrapping. Random enable gaps test stalling, and restarts and mid-run configuration changes test when a configuration takes effect. A wide-mode run with lower halves near the carry point shows whether carries reach the upper lane. Dual runs with skews of 0, 3 and 15 tell an aligned tap from a shifted one.

// File: rtl/abs_pkg.sv
package abs_pkg;
  parameter int unsigned LANE_W   = 12;
  parameter int unsigned CNT_W    = LANE_W + 1;
  parameter int unsigned MAX_SKEW = 15;
  localparam int unsigned SKEW_W  = $clog2(MAX_SKEW + 1);

  typedef logic [LANE_W-1:0] lane_addr_t;
  typedef logic [CNT_W-1:0]  lane_cnt_t;

  typedef struct packed {
    logic       valid;
    logic       done;
    lane_addr_t addr;
  } beat_t;
endpackage

// File: rtl/abs_seq_ctrl.sv
module abs_seq_ctrl
  import abs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      en,
  input  lane_cnt_t bsize,
  input  lane_cnt_t nblk,
  output logic      emit,
  output logic      blk_end,
  output logic      last
);
  lane_cnt_t k_q, k_d, b_q, b_d, bs_q, bs_d, nb_q, nb_d;
  logic      act_q, act_d;

  assign emit    = act_q & en & ~start;
  assign blk_end = emit & (k_q == bs_q - lane_cnt_t'(1));
  assign last    = blk_end & (b_q == nb_q - lane_cnt_t'(1));

  always_comb begin
    k_d   = k_q;
    b_d   = b_q;
    bs_d  = bs_q;
    nb_d  = nb_q;
    act_d = act_q;
    if (start) begin
      k_d   = '0;
      b_d   = '0;
      bs_d  = bsize;
      nb_d  = nblk;
      act_d = (bsize != '0) && (nblk != '0);
    end else if (emit) begin
      if (blk_end) begin
        k_d = '0;
        if (last) act_d = 1'b0;
        else      b_d   = b_q + lane_cnt_t'(1);
      end else begin
        k_d = k_q + lane_cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q   <= '0;
      b_q   <= '0;
      bs_q  <= '0;
      nb_q  <= '0;
      act_q <= 1'b0;
    end else begin
      k_q   <= k_d;
      b_q   <= b_d;
      bs_q  <= bs_d;
      nb_q  <= nb_d;
      act_q <= act_d;
    end
  end

  // R3: counters stay inside the captured geometry while running
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (k_q < bs_q) && (b_q < nb_q));

  // R6: the final emission ends the run
  p_last_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !act_q);

  // R12: empty geometry never starts a run
  p_empty_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (bsize == '0)) |=> !act_q);
endmodule

// File: rtl/abs_addr_lane.sv
module abs_addr_lane
  import abs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  lane_addr_t start_addr,
  input  lane_addr_t step,
  input  lane_addr_t bstep,
  input  logic       step_ev,
  input  logic       blk_ev,
  input  logic       cin_s,
  input  logic       cin_b,
  output lane_addr_t cur_addr,
  output logic       cout_s,
  output logic       cout_b
);
  lane_addr_t addr_q, addr_d, base_q, base_d, step_q, step_d, bstep_q, bstep_d;
  logic [LANE_W:0] sum_s, sum_b;

  assign sum_s    = {1'b0, addr_q} + {1'b0, step_q}  + {{LANE_W{1'b0}}, cin_s};
  assign sum_b    = {1'b0, base_q} + {1'b0, bstep_q} + {{LANE_W{1'b0}}, cin_b};
  assign cout_s   = sum_s[LANE_W];
  assign cout_b   = sum_b[LANE_W];
  assign cur_addr = addr_q;

  always_comb begin
    addr_d  = addr_q;
    base_d  = base_q;
    step_d  = step_q;
    bstep_d = bstep_q;
    if (start) begin
      addr_d  = start_addr;
      base_d  = start_addr;
      step_d  = step;
      bstep_d = bstep;
    end else if (blk_ev) begin
      base_d = sum_b[LANE_W-1:0];
      addr_d = sum_b[LANE_W-1:0];
    end else if (step_ev) begin
      addr_d = sum_s[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      base_q  <= '0;
      step_q  <= '0;
      bstep_q <= '0;
    end else begin
      addr_q  <= addr_d;
      base_q  <= base_d;
      step_q  <= step_d;
      bstep_q <= bstep_d;
    end
  end

  // R4: a new block begins exactly at its base
  p_block_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ev || start) |=> (cur_addr == base_q));

  // R7: no event leaves the address untouched
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !blk_ev && !step_ev) |=> $stable(cur_addr));
endmodule

// File: rtl/abs_skew_line.sv
module abs_skew_line
  import abs_pkg::*;
#(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = MAX_SKEW,
  localparam int unsigned SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  dout
);
  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = din;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[g] <= '0;
      else        tap[g] <= tap[g-1];
    end
  end

  assign dout = tap[sel];

  // R11: a steady one-cycle setting shows last cycle's input
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SW'(1)) && ($past(sel) == SW'(1)) |-> (dout == $past(din)));
endmodule

// File: rtl/abs_addr_seq.sv
module abs_addr_seq
  import abs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en,
  input  logic              wide_mode,
  input  logic [SKEW_W-1:0] skew,
  input  logic [LANE_W-1:0] lo_start,
  input  logic [LANE_W-1:0] lo_step,
  input  logic [LANE_W-1:0] lo_bstep,
  input  logic [CNT_W-1:0]  lo_bsize,
  input  logic [CNT_W-1:0]  lo_nblk,
  input  logic [LANE_W-1:0] hi_start,
  input  logic [LANE_W-1:0] hi_step,
  input  logic [LANE_W-1:0] hi_bstep,
  input  logic [CNT_W-1:0]  hi_bsize,
  input  logic [CNT_W-1:0]  hi_nblk,
  output logic              lo_valid,
  output logic              lo_done,
  output logic [LANE_W-1:0] lo_addr,
  output logic              hi_valid,
  output logic              hi_done,
  output logic [LANE_W-1:0] hi_addr
);
  localparam int unsigned BW = $bits(beat_t);

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic              wide_q, wide_d;
  logic [SKEW_W-1:0] skew_q, skew_d;
  beat_t             lo_q, lo_d, hp_q, hp_d, hi_out;

  logic a_emit, a_bend, a_last, b_emit, b_bend, b_last;
  logic h_emit, h_bend, h_last, h_step;
  logic a_cs, a_cb, unused_cs, unused_cb;
  lane_addr_t a_addr, b_addr;

  abs_seq_ctrl u_ctrl_lo (
    .clk(clk), .rst_n(rst_s), .start(start), .en(en),
    .bsize(lo_bsize), .nblk(lo_nblk),
    .emit(a_emit), .blk_end(a_bend), .last(a_last)
  );

  abs_seq_ctrl u_ctrl_hi (
    .clk(clk), .rst_n(rst_s), .start(start), .en(en),
    .bsize(hi_bsize), .nblk(hi_nblk),
    .emit(b_emit), .blk_end(b_bend), .last(b_last)
  );

  assign h_emit = wide_q ? a_emit : b_emit;
  assign h_bend = wide_q ? a_bend : b_bend;
  assign h_last = wide_q ? a_last : b_last;
  assign h_step = h_emit & ~h_bend;

  abs_addr_lane u_lane_lo (
    .clk(clk), .rst_n(rst_s), .start(start),
    .start_addr(lo_start), .step(lo_step), .bstep(lo_bstep),
    .step_ev(a_emit & ~a_bend), .blk_ev(a_bend),
    .cin_s(1'b0), .cin_b(1'b0),
    .cur_addr(a_addr), .cout_s(a_cs), .cout_b(a_cb)
  );

  abs_addr_lane u_lane_hi (
    .clk(clk), .rst_n(rst_s), .start(start),
    .start_addr(hi_start), .step(hi_step), .bstep(hi_bstep),
    .step_ev(h_step), .blk_ev(h_bend),
    .cin_s(wide_q & a_cs), .cin_b(wide_q & a_cb),
    .cur_addr(b_addr), .cout_s(unused_cs), .cout_b(unused_cb)
  );

  always_comb begin
    lo_d       = lo_q;
    lo_d.valid = a_emit;
    lo_d.done  = a_last;
    if (a_emit) lo_d.addr = a_addr;
    hp_d       = hp_q;
    hp_d.valid = h_emit;
    hp_d.done  = h_last;
    if (h_emit) hp_d.addr = b_addr;
    wide_d = start ? wide_mode : wide_q;
    skew_d = start ? skew : skew_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      lo_q   <= '0;
      hp_q   <= '0;
      wide_q <= 1'b0;
      skew_q <= '0;
    end else begin
      lo_q   <= lo_d;
      hp_q   <= hp_d;
      wide_q <= wide_d;
      skew_q <= skew_d;
    end
  end

  abs_skew_line #(.W(BW), .DEPTH(MAX_SKEW)) u_skew (
    .clk(clk), .rst_n(rst_s), .din(hp_q),
    .sel(wide_q ? '0 : skew_q), .dout(hi_out)
  );

  assign lo_valid = lo_q.valid;
  assign lo_done  = lo_q.done;
  assign lo_addr  = lo_q.addr;
  assign hi_valid = hi_out.valid;
  assign hi_done  = hi_out.done;
  assign hi_addr  = hi_out.addr;

  // R6: done only accompanies a valid address
  p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_s)
    lo_done |-> lo_valid);

  // R9: wide mode keeps the upper lane aligned with the lower lane
  p_wide_align_r9: assert property (@(posedge clk) disable iff (!rst_s)
    wide_q |-> (hi_valid == lo_valid) && (hi_done == lo_done));

  // R2: nothing is emitted in a start cycle
  p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s)
    start |=> !lo_valid);
endmodule

// File: tb/sim_abs_addr_seq.sv
`timescale 1ns/1ps
module sim_abs_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, en = 1'b0, wide_mode = 1'b0;
  logic [3:0]  skew = '0;
  logic [11:0] lo_start = '0, lo_step = '0, lo_bstep = '0;
  logic [11:0] hi_start = '0, hi_step = '0, hi_bstep = '0;
  logic [12:0] lo_bsize = '0, lo_nblk = '0, hi_bsize = '0, hi_nblk = '0;
  logic        lo_valid, lo_done, hi_valid, hi_done;
  logic [11:0] lo_addr, hi_addr;

  always #10 clk = ~clk;

  abs_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en), .wide_mode(wide_mode),
    .skew(skew), .lo_start(lo_start), .lo_step(lo_step), .lo_bstep(lo_bstep),
    .lo_bsize(lo_bsize), .lo_nblk(lo_nblk), .hi_start(hi_start),
    .hi_step(hi_step), .hi_bstep(hi_bstep), .hi_bsize(hi_bsize),
    .hi_nblk(hi_nblk), .lo_valid(lo_valid), .lo_done(lo_done),
    .lo_addr(lo_addr), .hi_valid(hi_valid), .hi_done(hi_done),
    .hi_addr(hi_addr)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit chk_on = 0, finished = 0;
  string tag_lo = "R1", tag_hi = "R1";

  // reference model state
  int q_lo[$], q_hi[$];
  int m_lv = 0, m_ld = 0, m_la = 0, p_v = 0, p_d = 0, p_a = 0;
  int e_hv = 0, e_hd = 0, e_ha = 0, m_dly = 0, m_wide = 0, mcyc = 0;
  int hv[32], hd[32], ha[32];
  int cnt_lv = 0, cnt_ld = 0, cnt_hv = 0;

  function automatic void build(ref int q[$], input int st, input int stp,
                                input int bs, input int nb, input int bst,
                                input int mask);
    q.delete();
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < bs; k++)
        q.push_back((st + b * bst + k * stp) & mask);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_lo.delete(); q_hi.delete();
      m_lv = 0; m_ld = 0; m_la = 0; p_v = 0; p_d = 0; p_a = 0;
      m_dly = 0; m_wide = 0; mcyc = 0;
      for (int i = 0; i < 32; i++) begin hv[i] = 0; hd[i] = 0; ha[i] = 0; end
    end else begin
      m_lv = 0; m_ld = 0; p_v = 0; p_d = 0;
      if (start) begin
        m_wide = wide_mode;
        m_dly  = wide_mode ? 0 : int'(skew);
        if (wide_mode) begin
          build(q_lo, {hi_start, lo_start}, {hi_step, lo_step}, lo_bsize,
                lo_nblk, {hi_bstep, lo_bstep}, 32'hFFFFFF);
          q_hi.delete();
        end else begin
          build(q_lo, lo_start, lo_step, lo_bsize, lo_nblk, lo_bstep, 32'hFFF);
          build(q_hi, hi_start, hi_step, hi_bsize, hi_nblk, hi_bstep, 32'hFFF);
        end
      end else if (en) begin
        if (q_lo.size() > 0) begin
          int a;
          a = q_lo.pop_front();
          m_lv = 1; m_ld = (q_lo.size() == 0); m_la = a & 32'hFFF;
          if (m_wide != 0) begin p_v = 1; p_d = m_ld; p_a = (a >> 12) & 32'hFFF; end
        end
        if (m_wide == 0 && q_hi.size() > 0) begin
          p_a = q_hi.pop_front(); p_v = 1; p_d = (q_hi.size() == 0);
        end
      end
      hv[mcyc % 32] = p_v; hd[mcyc % 32] = p_d; ha[mcyc % 32] = p_a;
      e_hv = hv[(mcyc + 32 - m_dly) % 32];
      e_hd = hd[(mcyc + 32 - m_dly) % 32];
      e_ha = ha[(mcyc + 32 - m_dly) % 32];
      mcyc++;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(tag_lo, {lo_valid, lo_done, lo_addr}, {m_lv[0], m_ld[0], m_la[11:0]}, "lo beat");
      check(tag_hi, {hi_valid, hi_done, hi_addr}, {e_hv[0], e_hd[0], e_ha[11:0]}, "hi beat");
      cnt_lv += lo_valid; cnt_ld += lo_done; cnt_hv += hi_valid;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  task automatic kick();
    @(posedge clk); #2 start = 1'b1; en = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  logic [7:0] lfsr = 8'h5A;
  task automatic run(int n, bit rnd);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      en = rnd ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  endtask

  task automatic set_lo(int st, int stp, int bst, int bs, int nb);
    lo_start = 12'(st); lo_step = 12'(stp); lo_bstep = 12'(bst);
    lo_bsize = 13'(bs); lo_nblk = 13'(nb);
  endtask

  task automatic set_hi(int st, int stp, int bst, int bs, int nb);
    hi_start = 12'(st); hi_step = 12'(stp); hi_bstep = 12'(bst);
    hi_bsize = 13'(bs); hi_nblk = 13'(nb);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle in reset
    check("R1", {lo_valid, lo_done, lo_addr, hi_valid, hi_done, hi_addr}, 0, "reset outputs");
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", {lo_valid, lo_done, lo_addr, hi_valid, hi_done, hi_addr}, 0, "after release");
    chk_on = 1;

    // count 0..7 and an independent hi lane
    tag_lo = "R2"; tag_hi = "R10";
    set_lo(0, 1, 0, 8, 1); set_hi(12'h100, 2, 12'h40, 4, 2);
    wide_mode = 0; skew = 0;
    kick(); cnt_lv = 0; cnt_ld = 0;
    run(20, 0);
    check("R6", cnt_ld, 1, "done pulses");
    check("R3", cnt_lv, 8, "addresses per block");

    // nested blocks, hi delayed 3
    tag_lo = "R4"; tag_hi = "R11";
    set_lo(5, 3, 100, 4, 3); set_hi(7, 1, 16, 3, 3); skew = 3;
    kick(); run(30, 0);

    // stalls
    tag_lo = "R7"; tag_hi = "R3";
    set_lo(12'h020, 5, 12'h100, 5, 4); set_hi(1, 2, 3, 6, 2); skew = 1;
    kick(); run(80, 1);

    // wrapping, maximal skew
    tag_lo = "R5"; tag_hi = "R5";
    set_lo(12'hFF0, 7, 12'h800, 10, 3); set_hi(12'hFFF, 12'hFFF, 1, 5, 2); skew = 15;
    kick(); run(60, 0);

    // restart mid run
    tag_lo = "R8"; tag_hi = "R8";
    set_lo(0, 1, 0, 16, 4); set_hi(0, 1, 0, 16, 4); skew = 2;
    kick(); run(10, 0);
    set_lo(12'h200, 4, 0, 6, 1); set_hi(12'h300, 8, 0, 3, 1); skew = 0;
    kick(); run(30, 1);

    // wide mode with carries, skew ignored
    tag_lo = "R9"; tag_hi = "R9";
    wide_mode = 1; skew = 7;
    set_lo(12'hFFE, 1, 12'h800, 4, 3); set_hi(12'h001, 0, 12'h002, 1, 1);
    kick(); run(30, 1);
    set_lo(12'hF00, 12'h0C0, 12'hA00, 3, 4); set_hi(12'hFFF, 0, 12'h010, 0, 0);
    kick(); run(30, 0);

    // config inputs change without start
    tag_lo = "R13"; tag_hi = "R13";
    wide_mode = 0; skew = 4;
    set_lo(12'h010, 2, 12'h040, 4, 4); set_hi(12'h800, 1, 12'h020, 4, 4);
    kick(); run(5, 0);
    wide_mode = 1; skew = 9;
    set_lo(12'h777, 9, 1, 2, 2); set_hi(12'h123, 3, 5, 9, 9);
    run(40, 0);

    // empty geometry
    tag_lo = "R12"; tag_hi = "R12";
    wide_mode = 0; skew = 0;
    set_lo(12'h055, 1, 1, 0, 5); set_hi(12'h066, 1, 1, 4, 0);
    kick(); cnt_lv = 0; cnt_hv = 0;
    run(20, 0);
    check("R12", cnt_lv, 0, "lo valid count");
    check("R12", cnt_hv, 0, "hi valid count");

    chk_on = 0;
    finish_run();
  end
endmodule